// File: doc/BRIEF.md
# Hash-Indexed Repeat Finder

This block walks through a byte buffer and searches for earlier occurrences of the data at each position. The buffer sits outside the block, behind a synchronous read port with one cycle of latency. The block gathers four consecutive bytes into a word and hashes that word. The hash selects one entry in a table. Each entry holds three things: the address where the word was last seen, the four data bytes seen there, and a valid flag. A candidate is therefore confirmed in the same cycle as the lookup, with no second read of the buffer. A confirmed candidate is then extended one byte at a time, and the table is updated at every position passed over, including positions inside a match.

Results leave the block as events through a valid/ready handshake. Each event carries three values: the number of literal bytes since the previous event, the backward distance to the earlier copy, and the match length. The caller loads the buffer, gives the byte count and pulses `start`. The block first clears every valid flag, then scans, and finally raises `done`. If a pending literal run grows beyond a limit, set by default to 300 bytes, the block reports the match at its minimum length of four and does not extend it, which keeps the output latency bounded.

Top module: `lz_match_finder`

## Requirements
- R1: After reset is released, `ev_valid` and `done` are both low until a scan produces a result.
- R2: When the word at the current position equals the word recorded for its hash, and that entry is valid, an event is emitted. Its offset is the current address minus the most recently recorded address of that word, and its length is at least 4. The word is the four bytes at the current position, with the earliest byte in the most significant position.
- R3: A confirmed match is extended one byte at a time past its first four bytes. The extension stops at the first byte that differs or at the end of the input, and the reported length counts every equal byte. The earlier copy may overlap the current one (offset smaller than length).
- R4: The literal count of an event equals the number of bytes between the end of the previous event (or address 0) and the start of the match.
- R5: When the literal count exceeds `LIT_LIMIT` (300 by default), the match is reported with length exactly 4 and is not extended. When the count equals the limit, the match is extended normally.
- R6: When fewer than 4 unscanned bytes remain, the block emits one final event carrying offset 0, length 0 and the count of the remaining literal bytes. This event is left out when that count is zero. After it, `done` stays high and no further event appears until the next `start`.
- R7: While `ev_valid` is high and `ev_ready` is low, the event fields hold steady. Each accepted handshake consumes exactly one event.
- R8: Every `start` clears all table entries before scanning begins, so data recorded by an earlier run never produces a match.
- R9: While a match is being extended, the table is rewritten at each position passed over, so a later search finds the newest of those positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a clear-then-scan run; accepted only when idle or done |
| total_len | input | ADDR_W+1 | Number of bytes in the buffer for this run |
| buf_addr | output | ADDR_W | Read address into the external buffer |
| buf_data | input | 8 | Buffer byte, valid one cycle after its address |
| ev_valid | output | 1 | An event is presented |
| ev_ready | input | 1 | Downstream accepts the event |
| ev_lit | output | ADDR_W+1 | Literal bytes preceding the match |
| ev_off | output | ADDR_W | Distance back to the earlier copy (0 in the final event) |
| ev_len | output | ADDR_W+1 | Match length (0 in the final event) |
| done | output | 1 | Scan complete; held until the next start |

## Verification
Before scanning, each run spends 2^HASH_BITS cycles on the clean pass. After that, each new word costs two cycles per fetched byte plus one lookup cycle, and each extended byte costs three cycles. An event can therefore appear at many different cycle counts. The bench does not count cycles to an event. It polls at falling edges until `ev_valid` rises and compares all three fields in that same half cycle; the rising edge that follows completes the handshake. Fixed cycle counts are used in only two places: the stall scenario, which checks the held fields at each of three falling edges while `ev_ready` is low, and the window after `done`, which is watched for five cycles for a stray event.

// File: rtl/lz_match_finder.sv
module lz_match_finder #(
  parameter int ADDR_W    = 16,
  parameter int HASH_BITS = 12,
  parameter int LIT_LIMIT = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   total_len,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_data,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [ADDR_W:0]   ev_lit,
  output logic [ADDR_W-1:0] ev_off,
  output logic [ADDR_W:0]   ev_len,
  output logic              done
);
  localparam int CW      = ADDR_W + 1;
  localparam int ENTRIES = 1 << HASH_BITS;
  localparam logic [CW-1:0] FOUR  = CW'(4);
  localparam logic [CW-1:0] THREE = CW'(3);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] LIM   = CW'(LIT_LIMIT);

  typedef enum logic [3:0] {
    S_IDLE, S_CLEAN, S_FETCH, S_LATCH, S_LOOK,
    S_EREF, S_ECUR, S_ECMP, S_EMIT, S_FIN, S_DONE
  } st_t;

  st_t st;
  logic [CW-1:0]        n, ip, rp, lit_start, mlen;
  logic [ADDR_W-1:0]    refp, off_r;
  logic [2:0]           have;
  logic [31:0]          word;
  logic [7:0]           rbyte;
  logic [HASH_BITS-1:0] clr;

  logic [ADDR_W-1:0] t_addr [ENTRIES];
  logic [31:0]       t_word [ENTRIES];
  logic              t_vld  [ENTRIES];

  function automatic logic [HASH_BITS-1:0] hash_of(input logic [31:0] w);
    logic [31:0] p;
    p = w * 32'h9E3779B1;
    return p[31 -: HASH_BITS];
  endfunction

  logic [31:0]          ext_word;
  logic [HASH_BITS-1:0] look_idx, ext_idx;
  logic [ADDR_W-1:0]    cand_addr, cand_off;
  logic [CW-1:0]        lit_now;
  logic                 hit, ext_ok;

  assign ext_word  = {word[23:0], buf_data};
  assign look_idx  = hash_of(word);
  assign ext_idx   = hash_of(ext_word);
  assign cand_addr = t_addr[look_idx];
  assign cand_off  = ip[ADDR_W-1:0] - cand_addr;
  assign hit       = t_vld[look_idx] && (t_word[look_idx] == word) && (cand_off != '0);
  assign ext_ok    = (buf_data == rbyte);
  assign lit_now   = ip - lit_start;

  assign buf_addr = (st == S_EREF) ? refp : rp[ADDR_W-1:0];
  assign ev_valid = (st == S_EMIT) || (st == S_FIN);
  assign ev_lit   = (st == S_FIN) ? (n - lit_start) : lit_now;
  assign ev_off   = (st == S_FIN) ? '0 : off_r;
  assign ev_len   = (st == S_FIN) ? '0 : mlen;
  assign done     = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (st == S_CLEAN) begin
      t_vld[clr] <= 1'b0;
    end else if (st == S_LOOK) begin
      t_addr[look_idx] <= ip[ADDR_W-1:0];
      t_word[look_idx] <= word;
      t_vld[look_idx]  <= 1'b1;
    end else if (st == S_ECMP && ext_ok) begin
      t_addr[ext_idx] <= ADDR_W'(rp - THREE);
      t_word[ext_idx] <= ext_word;
      t_vld[ext_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      n         <= '0;
      ip        <= '0;
      rp        <= '0;
      lit_start <= '0;
      mlen      <= '0;
      refp      <= '0;
      off_r     <= '0;
      have      <= '0;
      word      <= '0;
      rbyte     <= '0;
      clr       <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          n   <= total_len;
          clr <= '0;
          st  <= S_CLEAN;
        end
        S_CLEAN: begin
          clr <= clr + 1'b1;
          if (&clr) begin
            ip        <= '0;
            rp        <= '0;
            lit_start <= '0;
            have      <= '0;
            st        <= S_FETCH;
          end
        end
        S_FETCH:
          if (ip + FOUR > n) st <= (lit_start == n) ? S_DONE : S_FIN;
          else               st <= S_LATCH;
        S_LATCH: begin
          word <= ext_word;
          rp   <= rp + ONE;
          have <= have + 3'd1;
          st   <= (have == 3'd3) ? S_LOOK : S_FETCH;
        end
        S_LOOK:
          if (hit) begin
            off_r <= cand_off;
            mlen  <= FOUR;
            refp  <= cand_addr + ADDR_W'(4);
            st    <= (lit_now > LIM) ? S_EMIT : S_EREF;
          end else begin
            ip   <= ip + ONE;
            have <= 3'd3;
            st   <= S_FETCH;
          end
        S_EREF: st <= (rp >= n) ? S_EMIT : S_ECUR;
        S_ECUR: begin
          rbyte <= buf_data;
          st    <= S_ECMP;
        end
        S_ECMP:
          if (ext_ok) begin
            word <= ext_word;
            mlen <= mlen + ONE;
            rp   <= rp + ONE;
            refp <= refp + 1'b1;
            st   <= S_EREF;
          end else begin
            st <= S_EMIT;
          end
        S_EMIT: if (ev_ready) begin
          ip        <= rp;
          lit_start <= rp;
          have      <= '0;
          st        <= S_FETCH;
        end
        S_FIN: if (ev_ready) begin
          lit_start <= n;
          st        <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lz_match_finder_chk.sv
module lz_match_finder_chk #(
  parameter int ADDR_W    = 16,
  parameter int LIT_LIMIT = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [ADDR_W:0]   ev_lit,
  input logic [ADDR_W-1:0] ev_off,
  input logic [ADDR_W:0]   ev_len,
  input logic              done
);
  localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(LIT_LIMIT);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_lit) && $stable(ev_off) && $stable(ev_len));

  assert_min_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_len != '0 |-> ev_len >= (ADDR_W+1)'(4) && ev_off != '0);

  assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_len != '0 && ev_lit > LIM |-> ev_len == (ADDR_W+1)'(4));

  assert_final_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_len == '0 |-> ev_off == '0 && ev_lit != '0);

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ev_valid);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !ev_valid && !done);
endmodule

bind lz_match_finder lz_match_finder_chk #(.ADDR_W(ADDR_W), .LIT_LIMIT(LIT_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_lit(ev_lit), .ev_off(ev_off), .ev_len(ev_len), .done(done)
);

// File: tb/lz_match_finder_tb.sv
`timescale 1ns/1ps
module lz_match_finder_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW:0]   total_len = '0;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_data;
  logic          ev_valid;
  logic          ev_ready = 1'b1;
  logic [AW:0]   ev_lit;
  logic [AW-1:0] ev_off;
  logic [AW:0]   ev_len;
  logic          done;

  logic [7:0] mem [1024];
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) buf_data <= mem[buf_addr[9:0]];

  lz_match_finder #(.ADDR_W(AW), .HASH_BITS(12), .LIT_LIMIT(300)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .buf_addr(buf_addr), .buf_data(buf_data), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_lit(ev_lit), .ev_off(ev_off), .ev_len(ev_len), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_str(input int base, input string s);
    for (int i = 0; i < s.len(); i++) mem[base + i] = s[i];
  endtask

  task automatic launch(input int len);
    @(negedge clk);
    total_len = (AW+1)'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic take_ev(input string tag, input int lit, input int off, input int len);
    int w = 0;
    while (!ev_valid && !done && w < 20000) begin @(negedge clk); w++; end
    check({tag, " valid"}, int'(ev_valid), 1);
    check({tag, " lit"}, int'(ev_lit), lit);
    check({tag, " off"}, int'(ev_off), off);
    check({tag, " len"}, int'(ev_len), len);
    @(negedge clk);
  endtask

  task automatic expect_done(input string tag);
    int w = 0;
    while (!done && !ev_valid && w < 20000) begin @(negedge clk); w++; end
    check({tag, " done"}, int'(done), 1);
    check({tag, " no extra event"}, int'(ev_valid), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 ev_valid after reset", int'(ev_valid), 0);
    check("R1 done after reset", int'(done), 0);
  endtask

  // R2 R4 R9: "abcdefgh" x2, 'Q', "efgh"
  task automatic t_basic;
    put_str(0, "abcdefghabcdefghQefgh");
    launch(21);
    take_ev("R2/R4 first match", 8, 8, 8);
    take_ev("R9 newest position inside match", 1, 5, 4);
    expect_done("R6 basic end");
  endtask

  // R3: ten equal bytes, overlapping copy
  task automatic t_overlap;
    put_str(0, "aaaaaaaaaa");
    launch(10);
    take_ev("R3 overlapping run", 1, 1, 9);
    expect_done("R3 overlap end");
  endtask

  // R3 mismatch stop, R6 trailing literals
  task automatic t_tail;
    put_str(0, "abcdefghabcdXYZ");
    launch(15);
    take_ev("R3 stop at mismatch", 8, 8, 4);
    take_ev("R6 trailing literals", 3, 0, 0);
    expect_done("R6 tail end");
    repeat (5) @(negedge clk);
    check("R6 done held", int'(done), 1);
    check("R6 quiet after done", int'(ev_valid), 0);
  endtask

  task automatic fill_cap(input int f);
    for (int i = 0; i < f; i++) mem[i] = (i % 2 == 0) ? 8'(i / 2) : 8'hEE;
    for (int i = 0; i < 8; i++) begin
      mem[f + i]     = 8'(8'hF0 + i);
      mem[f + 8 + i] = 8'(8'hF0 + i);
    end
  endtask

  task automatic t_cap_edge;
    fill_cap(292);
    launch(308);
    take_ev("R5 literal count at limit extends", 300, 8, 8);
    expect_done("R5 edge end");
  endtask

  task automatic t_cap_over;
    fill_cap(293);
    launch(309);
    take_ev("R5 literal count over limit gives 4", 301, 8, 4);
    take_ev("R5 following match extends", 0, 8, 4);
    expect_done("R5 over end");
  endtask

  task automatic t_clean;
    for (int i = 0; i < 10; i++) mem[i] = 8'(8'h10 + i);
    put_str(10, "wxyz");
    launch(14);
    take_ev("R8 first run literals", 14, 0, 0);
    expect_done("R8 first run end");
    for (int i = 0; i < 20; i++) mem[i] = 8'(8'h30 + i);
    put_str(20, "wxyz");
    launch(24);
    take_ev("R8 stale entry ignored", 24, 0, 0);
    expect_done("R8 second run end");
  endtask

  task automatic t_stall;
    int w = 0;
    int l0, o0, n0;
    put_str(0, "abcdabcd");
    ev_ready = 1'b0;
    launch(8);
    while (!ev_valid && w < 20000) begin @(negedge clk); w++; end
    l0 = int'(ev_lit); o0 = int'(ev_off); n0 = int'(ev_len);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 valid held", int'(ev_valid), 1);
      check("R7 lit held", int'(ev_lit), l0);
      check("R7 off held", int'(ev_off), o0);
      check("R7 len held", int'(ev_len), n0);
    end
    ev_ready = 1'b1;
    take_ev("R7 stalled event", 4, 4, 4);
    expect_done("R7 single event");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_overlap();
    t_tail();
    t_cap_edge();
    t_cap_over();
    t_clean();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule